// File: doc/BRIEF.md
# I2C Master Bit-Timing Generator

This block produces the serial clock (SCL) and the data-line drive level (SDA) for an I2C master, together with one-cycle strobes that mark when outgoing data may change and when incoming data should be sampled. All timing comes from a fixed reference clock and three 32-bit configuration words. A byte engine above it issues bit-level requests: open a transaction (START), shift one bit, close the transaction (STOP), or park the clock low while it prepares more data.

Each bit is a low phase followed by a high phase. The phase lengths are programmed with a fixed hardware overhead removed: the low phase adds two reference cycles to its programmed count and the high phase adds seven. Inside the low phase a programmable drive point changes SDA. Inside the high phase a programmable sample point captures the line. After a START the block holds SDA low with SCL high for a lead-in time. After a STOP it enforces a bus-free interval before it accepts a new START. Between bits SCL rests high unless the engine asks to hold it low.

Configuration layout: word 0 carries the high count in bits 25:16 and the sample point in bits 15:0. Word 1 carries the low count in bits 25:16 and the drive point in bits 15:0. Word 2 carries the bus-free time in bits 31:16 and the lead-in time in bits 15:0.

Top module: `i2c_scl_timer`

## Requirements
- R1: While reset is asserted and in the cycle after it, scl_o and sda_o are 1, ready is 1, and drv_stb and smp_stb are 0.
- R2: In the idle state a start request pulls sda_o low in the next cycle while scl_o stays high. ready stays low for max(lead-in, 1) cycles and then returns high with scl_o still high.
- R3: A bit request accepted in a ready post-START state drives scl_o low for exactly (low count + 2) cycles.
- R4: That low phase is followed by scl_o high for exactly (high count + 7) cycles with ready low. ready then returns high with scl_o held high.
- R5: drv_stb pulses for one cycle in the low phase, at the cycle whose index from 0 equals the drive point. sda_o takes the requested bit_val in the next cycle and stays stable through the high phase.
- R6: smp_stb pulses for one cycle in the high phase, at the cycle whose index from 0 equals the sample point. rx_bit holds the sda_in value seen in that cycle.
- R7: A stop request gives a low phase of (low count + 2) cycles in which sda_o is driven to 0 at the drive point. Next comes a high phase of (high count + 7) cycles with sda_o at 0. sda_o then returns to 1 while scl_o is high.
- R8: After a STOP, ready stays low for max(bus free, 1) cycles with both lines high. A start request during that window is ignored.
- R9: A hold request in a ready post-START state drives scl_o low and keeps ready high for as long as no other request arrives. A later bit request then runs a full low phase of (low count + 2) cycles.
- R10: A start request outside the idle state is ignored. Bit, stop and hold requests in the idle state are ignored.
- R11: When several requests arrive together in a ready post-START state, stop wins over bit, and bit wins over hold.
- R12: drv_stb and smp_stb are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word0 | input | 32 | High count [25:16], sample point [15:0] |
| cfg_word1 | input | 32 | Low count [25:16], drive point [15:0] |
| cfg_word2 | input | 32 | Bus-free time [31:16], lead-in time [15:0] |
| req_start | input | 1 | Open a transaction (accepted only when idle) |
| req_bit | input | 1 | Shift one bit |
| bit_val | input | 1 | Bit to send with req_bit |
| req_stop | input | 1 | Close the transaction |
| req_hold | input | 1 | Park SCL low |
| sda_in | input | 1 | Sampled SDA line level |
| scl_o | output | 1 | SCL level (1 = released high) |
| sda_o | output | 1 | SDA drive level (1 = released high) |
| ready | output | 1 | Block accepts a request this cycle |
| drv_stb | output | 1 | SDA drive-point strobe |
| smp_stb | output | 1 | SDA sample-point strobe |
| rx_bit | output | 1 | Last sampled SDA value |

## Verification
On every cycle the assertions check the line levels during the START hold and the STOP high phase. They check that SDA stays still while SCL is high within a bit, that the phase counter never runs past its programmed limit, that the two strobes are exclusive, and that a parked clock stays parked. The exact phase lengths, the strobe positions, the captured receive bit, the request priority and the ignoring of misplaced requests show only in the bench's scenarios. Those scenarios time each phase at the ports for several configuration words, including all-zero counts.

// File: rtl/tgen_pkg.sv
package tgen_pkg;

    localparam int unsigned FIELD_W = 16;
    localparam int unsigned PHASE_W = 10;
    localparam int unsigned CNT_W   = FIELD_W + 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT_HI,
        ST_PARK,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_STOP_LO,
        ST_STOP_HI,
        ST_FREE
    } tgen_state_e;

    typedef struct packed {
        logic [PHASE_W-1:0] high_cnt;
        logic [FIELD_W-1:0] rx_pt;
        logic [PHASE_W-1:0] low_cnt;
        logic [FIELD_W-1:0] tx_pt;
        logic [FIELD_W-1:0] free_cnt;
        logic [FIELD_W-1:0] lead_cnt;
    } tgen_cfg_t;

    typedef struct packed {
        logic start;
        logic go_bit;
        logic stop;
        logic hold;
    } tgen_req_t;

    function automatic tgen_cfg_t unpack_cfg(input logic [31:0] w0,
                                             input logic [31:0] w1,
                                             input logic [31:0] w2);
        tgen_cfg_t c;
        c.high_cnt = w0[FIELD_W +: PHASE_W];
        c.rx_pt    = w0[FIELD_W-1:0];
        c.low_cnt  = w1[FIELD_W +: PHASE_W];
        c.tx_pt    = w1[FIELD_W-1:0];
        c.free_cnt = w2[31:FIELD_W];
        c.lead_cnt = w2[FIELD_W-1:0];
        return c;
    endfunction

    // index of the final cycle of a phase lasting len cycles (at least one)
    function automatic logic [CNT_W-1:0] last_idx(input logic [CNT_W-1:0] len);
        return (len == '0) ? '0 : (len - 1'b1);
    endfunction

    function automatic logic is_ready_state(input tgen_state_e s);
        return (s == ST_IDLE) || (s == ST_WAIT_HI) || (s == ST_PARK);
    endfunction

    function automatic logic is_scl_low(input tgen_state_e s);
        return (s == ST_BIT_LO) || (s == ST_STOP_LO) || (s == ST_PARK);
    endfunction

endpackage

// File: rtl/tgen_phase_cnt.sv
module tgen_phase_cnt
    import tgen_pkg::*;
#(
    parameter int unsigned W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt != {W{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tgen_phase_fsm.sv
module tgen_phase_fsm
    import tgen_pkg::*;
#(
    parameter int unsigned HIGH_EXTRA = 7,
    parameter int unsigned LOW_EXTRA  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  tgen_cfg_t        cfg,
    input  tgen_req_t        req,
    input  logic [CNT_W-1:0] cnt,
    output tgen_state_e      state,
    output logic             cnt_clr,
    output logic             drv_stb,
    output logic             drv_is_data,
    output logic             smp_stb,
    output logic             start_acc,
    output logic             bit_acc,
    output logic             free_enter
);

    tgen_state_e      nxt;
    logic [CNT_W-1:0] lo_last;
    logic [CNT_W-1:0] hi_last;
    logic [CNT_W-1:0] lead_last;
    logic [CNT_W-1:0] free_last;
    logic             in_lo;

    assign lo_last   = last_idx(CNT_W'(cfg.low_cnt) + CNT_W'(LOW_EXTRA));
    assign hi_last   = last_idx(CNT_W'(cfg.high_cnt) + CNT_W'(HIGH_EXTRA));
    assign lead_last = last_idx(CNT_W'(cfg.lead_cnt));
    assign free_last = last_idx(CNT_W'(cfg.free_cnt));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (req.start) nxt = ST_START;
            ST_START:   if (cnt >= lead_last) nxt = ST_WAIT_HI;
            ST_WAIT_HI,
            ST_PARK: begin
                if (req.stop)        nxt = ST_STOP_LO;
                else if (req.go_bit) nxt = ST_BIT_LO;
                else if (req.hold)   nxt = ST_PARK;
            end
            ST_BIT_LO:  if (cnt >= lo_last) nxt = ST_BIT_HI;
            ST_BIT_HI:  if (cnt >= hi_last) nxt = ST_WAIT_HI;
            ST_STOP_LO: if (cnt >= lo_last) nxt = ST_STOP_HI;
            ST_STOP_HI: if (cnt >= hi_last) nxt = ST_FREE;
            ST_FREE:    if (cnt >= free_last) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assign cnt_clr     = (nxt != state);
    assign in_lo       = (state == ST_BIT_LO) || (state == ST_STOP_LO);
    assign drv_stb     = in_lo && (cnt == CNT_W'(cfg.tx_pt));
    assign drv_is_data = (state == ST_BIT_LO);
    assign smp_stb     = (state == ST_BIT_HI) && (cnt == CNT_W'(cfg.rx_pt));
    assign start_acc   = (state == ST_IDLE) && (nxt == ST_START);
    assign bit_acc     = (nxt == ST_BIT_LO) && (state != ST_BIT_LO);
    assign free_enter  = (state == ST_STOP_HI) && (nxt == ST_FREE);

    // R8
    free_blocks_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FREE && req.start) |=> (state == ST_FREE || state == ST_IDLE));

    // R9
    park_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PARK && !req.stop && !req.go_bit) |=> (state == ST_PARK));

    // R3
    low_bound_chk: assert property (@(posedge clk) disable iff (rst)
        in_lo |-> (cnt <= lo_last));

    // R4
    high_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BIT_HI || state == ST_STOP_HI) |-> (cnt <= hi_last));

endmodule

// File: rtl/tgen_sda_path.sv
module tgen_sda_path (
    input  logic clk,
    input  logic rst,
    input  logic start_acc,
    input  logic bit_acc,
    input  logic free_enter,
    input  logic drv_stb,
    input  logic drv_is_data,
    input  logic smp_stb,
    input  logic bit_val,
    input  logic sda_in,
    output logic sda_o,
    output logic rx_bit
);

    logic tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_o  <= 1'b1;
            tx_q   <= 1'b1;
            rx_bit <= 1'b0;
        end else begin
            if (bit_acc) tx_q <= bit_val;

            if (start_acc)       sda_o <= 1'b0;
            else if (free_enter) sda_o <= 1'b1;
            else if (drv_stb)    sda_o <= drv_is_data ? tx_q : 1'b0;

            if (smp_stb) rx_bit <= sda_in;
        end
    end

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import tgen_pkg::*;
#(
    parameter int unsigned HIGH_EXTRA = 7,
    parameter int unsigned LOW_EXTRA  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] cfg_word0,
    input  logic [31:0] cfg_word1,
    input  logic [31:0] cfg_word2,
    input  logic        req_start,
    input  logic        req_bit,
    input  logic        bit_val,
    input  logic        req_stop,
    input  logic        req_hold,
    input  logic        sda_in,
    output logic        scl_o,
    output logic        sda_o,
    output logic        ready,
    output logic        drv_stb,
    output logic        smp_stb,
    output logic        rx_bit
);

    localparam int unsigned TOP_UNUSED = 32 - FIELD_W - PHASE_W;

    tgen_cfg_t        cfg;
    tgen_req_t        req;
    tgen_state_e      st;
    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    logic             drv_is_data;
    logic             start_acc;
    logic             bit_acc;
    logic             free_enter;
    logic             unused_cfg_bits;

    assign cfg = unpack_cfg(cfg_word0, cfg_word1, cfg_word2);
    assign req = '{start: req_start, go_bit: req_bit, stop: req_stop, hold: req_hold};
    assign unused_cfg_bits = ^{cfg_word0[31 -: TOP_UNUSED], cfg_word1[31 -: TOP_UNUSED]};

    tgen_phase_cnt #(.W(CNT_W)) i_cnt (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .cnt (cnt)
    );

    tgen_phase_fsm #(.HIGH_EXTRA(HIGH_EXTRA), .LOW_EXTRA(LOW_EXTRA)) i_fsm (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .req         (req),
        .cnt         (cnt),
        .state       (st),
        .cnt_clr     (cnt_clr),
        .drv_stb     (drv_stb),
        .drv_is_data (drv_is_data),
        .smp_stb     (smp_stb),
        .start_acc   (start_acc),
        .bit_acc     (bit_acc),
        .free_enter  (free_enter)
    );

    tgen_sda_path i_sda (
        .clk         (clk),
        .rst         (rst),
        .start_acc   (start_acc),
        .bit_acc     (bit_acc),
        .free_enter  (free_enter),
        .drv_stb     (drv_stb),
        .drv_is_data (drv_is_data),
        .smp_stb     (smp_stb),
        .bit_val     (bit_val),
        .sda_in      (sda_in),
        .sda_o       (sda_o),
        .rx_bit      (rx_bit)
    );

    assign scl_o = !is_scl_low(st);
    assign ready = is_ready_state(st);

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({drv_stb, smp_stb}));

    // R5
    sda_still_high_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BIT_HI && $past(st) == ST_BIT_HI) |-> $stable(sda_o));

    // R2
    start_level_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_START) |-> (!sda_o && scl_o));

    // R7
    stop_level_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STOP_HI) |-> (!sda_o && scl_o));

endmodule

// File: tb/test_i2c_scl_timer.sv
`timescale 1ns/1ps
module test_i2c_scl_timer;

    typedef struct packed {
        logic [9:0]  hi;
        logic [15:0] rxp;
        logic [9:0]  lo;
        logic [15:0] txp;
        logic [15:0] lead;
        logic [15:0] free;
        logic        b;
        logic        din;
    } vec_t;

    localparam int NVEC = 4;
    localparam vec_t VECS [NVEC] = '{
        '{10'd3,  16'd2, 10'd4,  16'd1, 16'd5, 16'd6, 1'b1, 1'b0},
        '{10'd0,  16'd0, 10'd0,  16'd0, 16'd0, 16'd0, 1'b0, 1'b1},
        '{10'd12, 16'd4, 10'd20, 16'd8, 16'd3, 16'd9, 1'b1, 1'b1},
        '{10'd1,  16'd7, 10'd2,  16'd3, 16'd1, 16'd2, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_word0 = '0;
    logic [31:0] cfg_word1 = '0;
    logic [31:0] cfg_word2 = '0;
    logic        req_start = 1'b0;
    logic        req_bit = 1'b0;
    logic        bit_val = 1'b0;
    logic        req_stop = 1'b0;
    logic        req_hold = 1'b0;
    logic        sda_in = 1'b1;
    logic        scl_o, sda_o, ready, drv_stb, smp_stb, rx_bit;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    i2c_scl_timer i_i2c_scl_timer (
        .clk(clk), .rst(rst),
        .cfg_word0(cfg_word0), .cfg_word1(cfg_word1), .cfg_word2(cfg_word2),
        .req_start(req_start), .req_bit(req_bit), .bit_val(bit_val),
        .req_stop(req_stop), .req_hold(req_hold), .sda_in(sda_in),
        .scl_o(scl_o), .sda_o(sda_o), .ready(ready),
        .drv_stb(drv_stb), .smp_stb(smp_stb), .rx_bit(rx_bit)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int at_least_one(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic load(input vec_t v);
        cfg_word0 = {6'd0, v.hi, v.rxp};
        cfg_word1 = {6'd0, v.lo, v.txp};
        cfg_word2 = {v.free, v.lead};
    endtask

    task automatic idle_check(input string tag);
        chk({tag, " scl"}, int'(scl_o), 1);
        chk({tag, " sda"}, int'(sda_o), 1);
        chk({tag, " ready"}, int'(ready), 1);
        chk({tag, " strobes"}, int'({drv_stb, smp_stb}), 0);
    endtask

    // measures an SCL-low phase; returns its length and the drive index
    task automatic run_low(output int len, output int di);
        len = 0; di = -1;
        while (!scl_o) begin
            if (drv_stb) di = len;
            len++;
            @(negedge clk);
        end
    endtask

    task automatic run_high(output int len, output int si);
        len = 0; si = -1;
        while (!ready) begin
            if (smp_stb) si = len;
            len++;
            @(negedge clk);
        end
    endtask

    task automatic do_start(input vec_t v);
        int n;
        req_start = 1'b1; @(negedge clk); req_start = 1'b0;
        chk("R2 sda low after start", int'(sda_o), 0);
        chk("R2 scl high after start", int'(scl_o), 1);
        n = 0;
        while (!ready) begin n++; @(negedge clk); end
        chk("R2 lead-in length", n, at_least_one(int'(v.lead)));
        chk("R2 scl high when ready", int'(scl_o), 1);
    endtask

    task automatic do_stop(input vec_t v);
        int n, di;
        req_stop = 1'b1; @(negedge clk); req_stop = 1'b0;
        run_low(n, di);
        chk("R7 stop low length", n, int'(v.lo) + 2);
        chk("R7 stop drive point", di, int'(v.txp));
        chk("R7 sda low in stop high", int'(sda_o), 0);
        n = 0;
        while (scl_o && !sda_o) begin n++; @(negedge clk); end
        chk("R7 stop high length", n, int'(v.hi) + 7);
        n = 0;
        while (!ready) begin
            if (!sda_o || !scl_o) n = n + 1000;
            n++;
            @(negedge clk);
        end
        chk("R8 bus free length", n, at_least_one(int'(v.free)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n, di, si;
        vec_t v;
        repeat (3) @(negedge clk);
        idle_check("R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        idle_check("R1 after reset");

        // table walk: start, one bit, stop per configuration
        for (int k = 0; k < NVEC; k++) begin
            v = VECS[k];
            load(v);
            @(negedge clk);
            do_start(v);
            bit_val = v.b; sda_in = v.din;
            req_bit = 1'b1; @(negedge clk); req_bit = 1'b0;
            run_low(n, di);
            chk("R3 low length", n, int'(v.lo) + 2);
            chk("R5 drive index", di, int'(v.txp));
            chk("R5 sda takes bit", int'(sda_o), int'(v.b));
            run_high(n, si);
            chk("R4 high length", n, int'(v.hi) + 7);
            chk("R6 sample index", si, int'(v.rxp));
            chk("R6 rx bit", int'(rx_bit), int'(v.din));
            chk("R4 scl high after bit", int'(scl_o), 1);
            chk("R5 sda held after bit", int'(sda_o), int'(v.b));
            sda_in = 1'b1;
            do_stop(v);
            idle_check("R8 idle after free");
        end

        v = VECS[0];
        load(v);

        // R10: bit, stop, hold while idle are ignored
        bit_val = 1'b0;
        req_bit = 1'b1; req_stop = 1'b1; req_hold = 1'b1;
        @(negedge clk);
        req_bit = 1'b0; req_stop = 1'b0; req_hold = 1'b0;
        idle_check("R10 requests in idle");

        // R10: start while already started is ignored
        do_start(v);
        req_start = 1'b1; @(negedge clk); req_start = 1'b0;
        chk("R10 second start ready", int'(ready), 1);
        chk("R10 second start scl", int'(scl_o), 1);
        chk("R10 second start sda", int'(sda_o), 0);

        // R9: hold parks SCL low indefinitely
        req_hold = 1'b1; @(negedge clk); req_hold = 1'b0;
        chk("R9 scl parked low", int'(scl_o), 0);
        chk("R9 ready while parked", int'(ready), 1);
        repeat (40) @(negedge clk);
        chk("R9 scl still low", int'(scl_o), 0);
        bit_val = 1'b1;
        req_bit = 1'b1; @(negedge clk); req_bit = 1'b0;
        run_low(n, di);
        chk("R9 low after park", n, int'(v.lo) + 2);
        run_high(n, si);
        chk("R9 high after park", n, int'(v.hi) + 7);

        // R11: bit wins over hold
        bit_val = 1'b0;
        req_bit = 1'b1; req_hold = 1'b1; @(negedge clk);
        req_bit = 1'b0; req_hold = 1'b0;
        run_low(n, di);
        chk("R11 bit over hold low", n, int'(v.lo) + 2);
        run_high(n, si);
        chk("R11 bit over hold scl high", int'(scl_o), 1);
        chk("R11 bit over hold sda", int'(sda_o), 0);

        // R11: stop wins over bit (bit value 1 would show as sda high)
        bit_val = 1'b1;
        req_stop = 1'b1; req_bit = 1'b1; @(negedge clk);
        req_stop = 1'b0; req_bit = 1'b0;
        run_low(n, di);
        chk("R11 stop over bit sda", int'(sda_o), 0);
        n = 0;
        while (scl_o && !sda_o) begin n++; @(negedge clk); end
        chk("R11 stop over bit high", n, int'(v.hi) + 7);

        // R8: start during bus free is ignored
        chk("R8 in free window", int'(ready), 0);
        req_start = 1'b1; @(negedge clk); req_start = 1'b0;
        n = 1;
        while (!ready) begin n++; @(negedge clk); end
        chk("R8 free length with start", n, int'(v.free));
        idle_check("R8 idle after ignored start");

        // R1: reset in the middle of a low phase
        do_start(v);
        req_bit = 1'b1; @(negedge clk); req_bit = 1'b0;
        @(negedge clk);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        idle_check("R1 mid-bit reset");

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule